// File: doc/BRIEF.md
# Interpolating Packed Audio Sample Player

This block plays back a stored sequence of 7-bit audio samples held two to a 14-bit memory word. Between every pair of neighbouring stored samples it inserts their average, so it emits two output levels per stored sample. The earlier sample of each word sits in the low half and the later one in the high half. The average that bridges two words uses the high sample of the previous word.

A start strobe loads a word address and a stored-sample count. Each timing tick then moves playback on by one output level. The level the block presents is the one that a double-buffered PWM duty register takes up at the following tick. When the block is idle, or once the sequence is used up, each tick presents the zero level of 64. Stored words come from a synchronous read port with one clock of latency.

Top module: `interp_sample_player`

## Requirements
- R1: A memory word holds the earlier sample in bits 6:0 and the later sample in bits 13:7.
- R2: A start with stored count N plays exactly 2N output levels. `busy_o` stays high until the tick that produces the last of them. With N odd, the high sample of the last word is never played.
- R3: An internal position holds the word address above a 2-bit phase and steps by one on each playing tick. A read (`mem_rd_o` high, `mem_addr_o` = start address + k) is issued only on the tick whose phase is 0 for word k.
- R4: At phase 0 the output is the average of the held previous high sample and the low sample of the newly read word. Both halves of that word are then held.
- R5: Phase 1 outputs the held low sample, phase 2 the average of the held low and high samples, and phase 3 the held high sample.
- R6: An average is the 8-bit sum of two samples shifted right by one, with the remainder dropped.
- R7: A start sets the held previous high sample to 64, so the first output is the average of 64 and the first stored sample.
- R8: A start with count zero leaves `busy_o` low and `level_o` unchanged.
- R9: After reset, `level_o` is 64 and `busy_o` is low. A tick while idle sets `level_o` to 64.
- R10: `level_o` changes only in response to a tick, a completed read, or a start. The new value is in place by the second clock after the tick.
- R11: A start during playback drops the current sequence and plays the new one from its beginning, again with a previous high of 64.
- R12: Read data is sampled exactly one clock after `mem_rd_o` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Load a new sequence |
| start_addr_i | input | ADDR_W | First word address of the sequence |
| start_count_i | input | CNT_W | Number of stored samples |
| tick_i | input | 1 | One-clock output-rate strobe |
| mem_rd_o | output | 1 | Read request to sample memory |
| mem_addr_o | output | ADDR_W | Word address of the read |
| mem_data_i | input | 14 | Word data, valid one clock after the request |
| level_o | output | 7 | Level for the PWM at the next tick |
| busy_o | output | 1 | Playback active |

## Verification
The assertions take it for granted that ticks are at least two clocks apart, so that a read completes before the next tick arrives. They also take the read data to be valid exactly one clock after each request. The bench drives each tick for one clock, then waits several clocks before the next, and its memory model registers data on the request edge. Start strobes never coincide with a tick. Between them, the sweeps over counts and base addresses cover odd counts, zero counts, word crossings and extreme sample values.

// File: rtl/player_pkg.sv
package player_pkg;
  localparam int SAMP_W = 7;
  localparam int WORD_W = 2 * SAMP_W;

  typedef enum logic [1:0] {
    PH_JOIN = 2'd0,
    PH_LOW  = 2'd1,
    PH_MID  = 2'd2,
    PH_HIGH = 2'd3
  } phase_e;

  function automatic logic [SAMP_W-1:0] mean2(input logic [SAMP_W-1:0] a,
                                              input logic [SAMP_W-1:0] b);
    logic [SAMP_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[SAMP_W:1];
  endfunction
endpackage

// File: rtl/player_seq.sv
module player_seq
  import player_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [CNT_W-1:0]  start_count_i,
  input  logic              tick_i,
  output logic              step_o,
  output phase_e            phase_o,
  output logic [ADDR_W-1:0] word_addr_o,
  output logic              active_o
);
  localparam int POS_W  = ADDR_W + 2;
  localparam int LEFT_W = CNT_W + 1;

  logic [POS_W-1:0]  pos_q;
  logic [LEFT_W-1:0] left_q;
  logic              active_q;

  assign step_o      = tick_i & active_q & ~start_i;
  assign phase_o     = phase_e'(pos_q[1:0]);
  assign word_addr_o = pos_q[POS_W-1:2];
  assign active_o    = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q    <= '0;
      left_q   <= '0;
      active_q <= 1'b0;
    end else if (start_i) begin
      pos_q    <= {start_addr_i, 2'b00};
      left_q   <= {start_count_i, 1'b0};
      active_q <= |start_count_i;
    end else if (step_o) begin
      pos_q  <= pos_q + 1'b1;
      left_q <= left_q - 1'b1;
      if (left_q == LEFT_W'(1)) active_q <= 1'b0;
    end
  end

  assert_pos_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> pos_q == $past(pos_q) + 1'b1);
  assert_live_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> left_q != '0);
  assert_stop_last_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_q) |-> $past(start_i) || $past(left_q) == LEFT_W'(1));
endmodule

// File: rtl/player_dp.sv
module player_dp
  import player_pkg::*;
#(
  parameter logic [6:0] ZERO_LVL = 7'd64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              step_i,
  input  phase_e            phase_i,
  input  logic              idle_tick_i,
  input  logic [WORD_W-1:0] mem_data_i,
  output logic              mem_rd_o,
  output logic [SAMP_W-1:0] level_o
);
  logic              pend_q;
  logic [SAMP_W-1:0] low_q, high_q, level_q;
  logic [SAMP_W-1:0] new_low, new_high;

  assign mem_rd_o = step_i && (phase_i == PH_JOIN);
  assign new_low  = mem_data_i[SAMP_W-1:0];
  assign new_high = mem_data_i[WORD_W-1:SAMP_W];
  assign level_o  = level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= mem_rd_o & ~start_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q   <= ZERO_LVL;
      high_q  <= ZERO_LVL;
      level_q <= ZERO_LVL;
    end else if (start_i) begin
      high_q <= ZERO_LVL;
    end else if (pend_q) begin
      level_q <= mean2(high_q, new_low);
      low_q   <= new_low;
      high_q  <= new_high;
    end else if (step_i) begin
      unique case (phase_i)
        PH_LOW:  level_q <= low_q;
        PH_MID:  level_q <= mean2(low_q, high_q);
        PH_HIGH: level_q <= high_q;
        default: ;
      endcase
    end else if (idle_tick_i) begin
      level_q <= ZERO_LVL;
    end
  end

  assert_read_lat_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o && !start_i |=> pend_q);
  assert_tick_gap_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pend_q && step_i));
  assert_level_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(level_q) |-> $past(pend_q || step_i || idle_tick_i));
endmodule

// File: rtl/interp_sample_player.sv
module interp_sample_player
  import player_pkg::*;
#(
  parameter int         ADDR_W   = 14,
  parameter int         CNT_W    = 16,
  parameter logic [6:0] ZERO_LVL = 7'd64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [CNT_W-1:0]  start_count_i,
  input  logic              tick_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [13:0]       mem_data_i,
  output logic [6:0]        level_o,
  output logic              busy_o
);
  logic   step, active, idle_tick;
  phase_e phase;

  player_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_seq (
    .clk_i, .rst_ni, .start_i, .start_addr_i, .start_count_i, .tick_i,
    .step_o(step), .phase_o(phase), .word_addr_o(mem_addr_o), .active_o(active)
  );

  assign idle_tick = tick_i & ~active & ~start_i;
  assign busy_o    = active;

  player_dp #(.ZERO_LVL(ZERO_LVL)) i_dp (
    .clk_i, .rst_ni, .start_i, .step_i(step), .phase_i(phase),
    .idle_tick_i(idle_tick), .mem_data_i, .mem_rd_o, .level_o
  );

  assert_rd_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> busy_o);
  assert_idle_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !busy_o && !start_i |=> level_o == ZERO_LVL);
  assert_empty_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && start_count_i == '0 |=> !busy_o && $stable(level_o));
endmodule

// File: tb/test_interp_sample_player.sv
module test_interp_sample_player;
  localparam int AW = 14, CW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, tick = 1'b0;
  logic [AW-1:0] s_addr = '0, m_addr;
  logic [CW-1:0] s_cnt = '0;
  logic m_rd, busy;
  logic [13:0] m_data = '0;
  logic [6:0] level;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  interp_sample_player i_interp_sample_player (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_addr_i(s_addr),
    .start_count_i(s_cnt), .tick_i(tick), .mem_rd_o(m_rd), .mem_addr_o(m_addr),
    .mem_data_i(m_data), .level_o(level), .busy_o(busy));

  // R1: low 7 bits earlier, high 7 bits later
  function automatic logic [13:0] word_of(input logic [AW-1:0] a);
    if (a[3:0] == 4'hF) return 14'h3FFF;
    if (a[3:0] == 4'hE) return 14'h0000;
    return {7'((a * 53 + 11) & 127), 7'((a * 37 + 5) & 127)};
  endfunction

  always_ff @(posedge clk) if (m_rd) m_data <= word_of(m_addr);

  function automatic logic [6:0] stored(input logic [AW-1:0] base, input int k);
    logic [13:0] w;
    w = word_of(AW'(base + AW'(k / 2)));
    return (k % 2 == 0) ? w[6:0] : w[13:7];
  endfunction

  function automatic logic [6:0] avg(input logic [6:0] a, input logic [6:0] b);
    return 7'((int'(a) + int'(b)) / 2);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_start(input logic [AW-1:0] a, input int n);
    @(negedge clk); start = 1'b1; s_addr = a; s_cnt = CW'(n);
    @(negedge clk); start = 1'b0;
    @(negedge clk);
  endtask

  // tick; check read request in the tick cycle, level two clocks later
  task automatic do_tick(input logic [AW-1:0] base, input int j, input bit live,
                         input int exp_lvl);
    @(negedge clk); tick = 1'b1;
    #1;
    if (live) begin
      chk("R3 rd", int'(m_rd), int'(j % 4 == 0));
      if (j % 4 == 0) chk("R3 addr", int'(m_addr), int'(AW'(base + AW'(j / 4))));
    end else chk("R3 idle rd", int'(m_rd), 0);
    @(negedge clk); tick = 1'b0;
    @(negedge clk);
    chk(live ? "R4 R5 R6 R10 level" : "R9 idle level", int'(level), exp_lvl);
    repeat (2) @(negedge clk);
  endtask

  function automatic int expect_out(input logic [AW-1:0] base, input int j);
    int m;
    m = j / 2;
    if (j % 2 == 1) return int'(stored(base, m));
    return int'(avg(m == 0 ? 7'd64 : stored(base, m - 1), stored(base, m)));  // R7
  endfunction

  task automatic play(input logic [AW-1:0] base, input int n, input int upto);
    do_start(base, n);
    chk("R2 R8 busy at start", int'(busy), int'(n != 0));
    for (int j = 0; j < upto; j++) begin
      do_tick(base, j, 1'b1, expect_out(base, j));
      chk("R2 busy", int'(busy), int'(j + 1 < 2 * n));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset level", int'(level), 64);
    chk("R9 reset busy", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    do_tick('0, 0, 1'b0, 64);
    // sweep counts and bases, including words of all ones and zeros
    for (int n = 1; n <= 7; n++)
      for (int b = 0; b < 4; b++) begin
        play(AW'(b * 5 + n + 9), n, 2 * n);
        do_tick('0, 0, 1'b0, 64);  // R9 after end, R2 odd count stops
        chk("R2 stays idle", int'(busy), 0);
      end
    // R8: zero count leaves level untouched
    play(AW'(3), 2, 2);
    begin
      int held;
      held = int'(level);
      do_start(AW'(40), 0);
      chk("R8 level held", int'(level), held);
      chk("R8 busy", int'(busy), 0);
    end
    // R11: restart mid-sequence
    play(AW'(20), 6, 5);
    play(AW'(61), 3, 6);
    chk("R11 ended", int'(busy), 0);
    play(AW'(100), 4, 3);
    play(AW'(13), 2, 4);
    do_tick('0, 0, 1'b0, 64);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule